// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Chain

A set of interrupt nodes, one per device, sharing a single request line toward a processor. Each node latches a local request as pending. The chain ORs the pending flags of all nodes onto one request output. When the processor raises its acknowledge, the acknowledge enters node 0 and passes from node to node. A node that has nothing pending passes it on. The first node with a pending request keeps it and puts its own fixed 8-bit vector on the shared vector output. Nodes further down the chain never see the acknowledge.

When the processor drops the acknowledge, the node that was driving clears its pending flag. The next acknowledge then reaches the next requester in chain order. Node vectors are computed from two parameters as `VEC_BASE + i*VEC_STEP`, modulo 256. All outputs of the chain come from registers.

Top module: `dc_chain`

## Requirements
- R1: A high `req_i[i]` at a clock edge sets node i's pending flag after that edge, and `irq_o` is high after the following edge.
- R2: `irq_o` is low whenever no node has been pending for the last two edges; it reflects the OR of all pending flags with one register of delay.
- R3: While `ack_i` is high at an edge, the lowest-index pending node is granted. After that edge, `drv_o` has only that node's bit set, `vec_vld_o` is 1 and `vec_o` equals `VEC_BASE + i*VEC_STEP` (8 bits, wrapping).
- R4: At most one bit of `drv_o` is ever set. When `vec_vld_o` is 0, `vec_o` is 0.
- R5: A pending node with a lower-index pending node ahead of it does not receive the acknowledge and does not drive.
- R6: After the acknowledge falls, the node that was driving clears its pending flag at the next edge. A later acknowledge serves the next pending node in index order.
- R7: A request that arrives at the same edge as the node's clear keeps the node pending.
- R8: While `rst` is high, all pending flags and all outputs are cleared to 0.
- R9: An acknowledge with no node pending leaves `drv_o`, `vec_vld_o` and `vec_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NODES | Per-node request, bit i for node i |
| ack_i | input | 1 | Processor acknowledge, enters node 0 |
| irq_o | output | 1 | Registered OR of all pending flags |
| vec_o | output | VEC_W | Registered vector of the driving node, 0 when none |
| vec_vld_o | output | 1 | Registered: some node drives `vec_o` |
| drv_o | output | NODES | Registered one-hot (or zero) of the driving node |

## Verification
The bench builds the chain with six nodes, base 0x80 and step 0x03. With these values every vector is distinct and non-zero, so a wrong node index or a missing vector shows up as a mismatch. Six positions leave room for requesters at the front, in the middle and at the far end of the chain at the same time. Random request patterns are drained one acknowledge at a time, which forces each grant to pass over a varying number of idle and already-served nodes.

// File: rtl/dc_pkg.sv
package dc_pkg;
  // Vector value of node idx: base + idx*step, truncated to 8 bits by callers.
  function automatic logic [31:0] node_vec(input int base, input int step, input int idx);
    return 32'(base + idx * step);
  endfunction
endpackage

// File: rtl/dc_node.sv
module dc_node #(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             pi_i,
  output logic             po_o,
  output logic             pend_o,
  output logic             grant_o,
  output logic [VEC_W-1:0] vec_o
);
  logic pend_q;
  logic gnt_q;
  logic clr;

  assign grant_o = pend_q & pi_i;
  assign po_o    = pi_i & ~pend_q;
  assign pend_o  = pend_q;
  assign vec_o   = grant_o ? VEC : '0;
  // acknowledge fell while this node held it
  assign clr     = gnt_q & ~pi_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      gnt_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr) | req_i;
      gnt_q  <= grant_o;
    end
  end
endmodule

// File: rtl/dc_vec_or.sv
module dc_vec_or #(
  parameter int NODES = 4,
  parameter int VEC_W = 8
) (
  input  logic [NODES*VEC_W-1:0] vec_i,
  output logic [VEC_W-1:0]       vec_o
);
  always_comb begin
    vec_o = '0;
    for (int i = 0; i < NODES; i++) begin
      vec_o = vec_o | vec_i[i*VEC_W +: VEC_W];
    end
  end
endmodule

// File: rtl/dc_chain.sv
module dc_chain #(
  parameter int NODES    = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32,
  parameter int VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NODES-1:0] req_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_vld_o,
  output logic [NODES-1:0] drv_o
);
  localparam int VBUS_W = NODES * VEC_W;

  logic [NODES:0]      prio;
  logic [NODES-1:0]    pend;
  logic [NODES-1:0]    grant;
  logic [VBUS_W-1:0]   vbus;
  logic [VEC_W-1:0]    vsel;

  assign prio[0] = ack_i;

  for (genvar i = 0; i < NODES; i++) begin : g_node
    localparam logic [31:0] VFULL = dc_pkg::node_vec(VEC_BASE, VEC_STEP, i);
    dc_node #(
      .VEC_W (VEC_W),
      .VEC   (VFULL[VEC_W-1:0])
    ) u_node (
      .clk     (clk),
      .rst     (rst),
      .req_i   (req_i[i]),
      .pi_i    (prio[i]),
      .po_o    (prio[i+1]),
      .pend_o  (pend[i]),
      .grant_o (grant[i]),
      .vec_o   (vbus[i*VEC_W +: VEC_W])
    );
  end

  dc_vec_or #(.NODES(NODES), .VEC_W(VEC_W)) u_vor (
    .vec_i (vbus),
    .vec_o (vsel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      vec_o     <= '0;
      vec_vld_o <= 1'b0;
      drv_o     <= '0;
    end else begin
      irq_o     <= |pend;
      vec_o     <= vsel;
      vec_vld_o <= |grant;
      drv_o     <= grant;
    end
  end
endmodule

// File: rtl/dc_chain_chk.sv
module dc_chain_chk #(
  parameter int NODES = 4,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NODES-1:0] req_i,
  input logic             ack_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_vld_o,
  input logic [NODES-1:0] drv_o,
  input logic [NODES-1:0] pend
);
  a_r4_single_driver: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drv_o));

  a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !vec_vld_o |-> (vec_o == '0));

  a_r9_no_ack_no_drive: assert property (@(posedge clk) disable iff (rst)
    !$past(ack_i) |-> (!vec_vld_o && drv_o == '0));

  a_r1_req_raises_irq: assert property (@(posedge clk) disable iff (rst)
    (|req_i) |-> ##2 irq_o);

  a_r3_valid_has_driver: assert property (@(posedge clk) disable iff (rst)
    vec_vld_o |-> (drv_o != '0));

  for (genvar j = 0; j < NODES; j++) begin : g_chk
    localparam logic [NODES-1:0] LOW = NODES'((64'd1 << j) - 64'd1);
    // R5: driver was pending and nothing ahead of it was pending
    a_r5_lowest_wins: assert property (@(posedge clk) disable iff (rst)
      drv_o[j] |-> ($past(pend[j]) && (($past(pend) & LOW) == '0)));
  end
endmodule

bind dc_chain dc_chain_chk #(.NODES(NODES), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_i     (req_i),
  .ack_i     (ack_i),
  .irq_o     (irq_o),
  .vec_o     (vec_o),
  .vec_vld_o (vec_vld_o),
  .drv_o     (drv_o),
  .pend      (pend)
);

// File: tb/sim_dc_chain.sv
module sim_dc_chain;
  localparam int N    = 6;
  localparam int W    = 8;
  localparam int BASE = 128;
  localparam int STEP = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic         ack = 1'b0;
  logic         irq;
  logic [W-1:0] vec;
  logic         vld;
  logic [N-1:0] drv;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dc_chain #(.NODES(N), .VEC_W(W), .VEC_BASE(BASE), .VEC_STEP(STEP)) u0 (
    .clk(clk), .rst(rst), .req_i(req), .ack_i(ack),
    .irq_o(irq), .vec_o(vec), .vec_vld_o(vld), .drv_o(drv)
  );

  // reference model state
  bit     m_pend [N];
  int     m_held = -1;     // node granted in previous cycle
  bit     m_irq  = 0;
  int     m_drv  = -1;     // node driving the outputs, -1 none

  function automatic logic [W-1:0] exp_vec(int idx);
    int v;
    v = (BASE + STEP * idx) % 256;
    return W'(v);
  endfunction

  function automatic logic [N-1:0] exp_drv(int idx);
    logic [N-1:0] r;
    r = '0;
    if (idx >= 0) r[idx] = 1'b1;
    return r;
  endfunction

  always @(posedge clk) begin
    int  first;
    bit  any;
    bit  nxt [N];
    if (rst) begin
      for (int i = 0; i < N; i++) m_pend[i] = 0;
      m_held = -1; m_irq = 0; m_drv = -1;
    end else begin
      first = -1; any = 0;
      for (int i = 0; i < N; i++) begin
        if (m_pend[i]) begin
          any = 1;
          if (first < 0) first = i;
        end
      end
      for (int i = 0; i < N; i++) begin
        nxt[i] = m_pend[i];
        if (m_held == i && !ack) nxt[i] = 0;
        if (req[i]) nxt[i] = 1;
      end
      m_irq  = any;
      m_drv  = (ack && first >= 0) ? first : -1;
      m_held = m_drv;
      for (int i = 0; i < N; i++) m_pend[i] = nxt[i];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irq == m_irq, "R1/R2 irq", int'(irq), int'(m_irq));
      chk(drv == exp_drv(m_drv), "R3/R5 drv", int'(drv), int'(exp_drv(m_drv)));
      chk(vld == (m_drv >= 0), "R3 vld", int'(vld), int'(m_drv >= 0));
      chk(vec == ((m_drv >= 0) ? exp_vec(m_drv) : '0), "R3/R4 vec",
          int'(vec), int'((m_drv >= 0) ? exp_vec(m_drv) : '0));
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req(logic [N-1:0] p);
    req = p; step(); req = '0; step();
  endtask

  initial begin
    step(4);
    chk(irq == 0 && vld == 0 && drv == '0 && vec == '0, "R8 reset outputs",
        int'({irq, vld, drv}), 0);
    rst = 1'b0;
    step(2);

    // R9: acknowledge with nothing pending
    ack = 1; step();
    chk(vld == 0 && drv == '0 && vec == '0, "R9 empty ack", int'(drv), 0);
    ack = 0; step(2);

    // R1: single request at node 2
    pulse_req(N'(4));
    chk(irq == 1, "R1 irq raised", int'(irq), 1);
    ack = 1; step();
    chk(drv == N'(4) && vec == exp_vec(2), "R3 node2 vector", int'(vec), int'(exp_vec(2)));
    step();
    ack = 0; step(2);
    chk(irq == 0, "R6 cleared, R2 irq low", int'(irq), 0);

    // R5: nodes 1 and 3 pending, node 1 wins, node 3 next (R6)
    pulse_req(N'(10));
    ack = 1; step();
    chk(drv == N'(2) && vec == exp_vec(1), "R5 front node wins", int'(vec), int'(exp_vec(1)));
    ack = 0; step(2);
    chk(irq == 1, "R6 node3 still pending", int'(irq), 1);
    ack = 1; step();
    chk(drv == N'(8) && vec == exp_vec(3), "R6 next requester", int'(vec), int'(exp_vec(3)));
    ack = 0; step(3);

    // R5: far end node behind all idle nodes
    pulse_req(N'(1 << (N-1)));
    ack = 1; step();
    chk(drv == N'(1 << (N-1)) && vec == exp_vec(N-1), "R5 last node",
        int'(vec), int'(exp_vec(N-1)));
    ack = 0; step(3);

    // R7: new request on the edge of the clear keeps node 0 pending
    pulse_req(N'(1));
    ack = 1; step();
    chk(drv == N'(1), "R3 node0 drives", int'(drv), 1);
    ack = 0; req = N'(1); step();
    req = '0; step(2);
    chk(irq == 1, "R7 pending kept", int'(irq), 1);
    ack = 1; step();
    chk(drv == N'(1) && vec == exp_vec(0), "R7 node0 again", int'(vec), int'(exp_vec(0)));
    ack = 0; step(3);

    // random patterns drained one acknowledge at a time
    for (int it = 0; it < 300; it++) begin
      logic [N-1:0] pat;
      int guard;
      pat = N'($urandom);
      pulse_req(pat);
      guard = 0;
      while (irq && guard < 2 * N) begin
        ack = 1; step(1 + ($urandom % 2));
        chk($countones(drv) == 1, "R4 exactly one driver", $countones(drv), 1);
        ack = 0; step(2);
        guard++;
      end
      chk(irq == 0, "R6 chain drained", int'(irq), 0);
      step();
    end

    // R8: reset in the middle of pending requests
    pulse_req('1);
    rst = 1; step(2);
    chk(irq == 0 && drv == '0, "R8 reset clears", int'(irq), 0);
    rst = 0; step(3);
    chk(irq == 0, "R8 nothing pending after reset", int'(irq), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule